// File: doc/BRIEF.md
# Fat-Tree Adaptive Route Selector

This block makes the per-packet routing decision for one eight-port switch element of a fat tree with four-way branching. Ports 0 to 3 lead down toward the nodes and ports 4 to 7 lead up toward the root. For each packet header it takes the destination node address and decides between two routes. It compares the address with the switch's configured tree level and position prefix. On a down route the output port comes straight from the address. On an up route the block picks the least-loaded enabled up link, so traffic spreads over the four alternatives and avoids links that are switched off.

Each up link carries a count of packets still waiting for an acknowledge. The count rises when a packet is granted to that link and falls when the acknowledge comes back on it. For every grant the block writes the input port into a return-path table indexed by the output port. When an acknowledge later arrives on that output port, the table gives at once the port the acknowledge must leave on.

Requests enter through a valid/ready stream. A request is taken when `req_valid` and `req_ready` are both high at a clock edge, and `req_ready` is high whenever the result register is empty or is being emptied in the same cycle. The routing result is offered on a valid/ready stream. It appears the cycle after the request is taken and stays unchanged until `res_ready` takes it. Acknowledges, configuration and link enables are plain signals with no handshake.

Top module: `adaptive_route_sel`

## Requirements
- R1: After reset `res_valid` and `ret_valid` are low, `req_ready` is high, and every up-link load is zero.
- R2: The address is read as 2-bit digits, digit k at bits [2k+1:2k]. When every digit above `cfg_level` equals the same digit of `cfg_prefix`, the result is a down route: `res_up`=0, `res_err`=0, and `res_port` = {0, address digit at `cfg_level`}, which is port 0 to 3.
- R3: A switch whose level is the top level (LEVELS-1) has no digits above it, so it routes every packet down.
- R4: In any other case the result is an up route with `res_up`=1 and `res_port`=4+i. Here i is the enabled up link (bit i of `up_enable`) with the smallest load. When loads are equal the lowest i wins.
- R5: An up link's load rises by one when a request is granted to it. It falls by one, but not below zero, when `ack_valid` is high with `ack_port`=4+i. Acknowledges on ports 0 to 3 leave the loads unchanged.
- R6: A disabled up link is never granted. When an up route is needed and `up_enable` is 0, the result has `res_err`=1, `res_up`=1 and `res_port`=0, no load changes, and the return-path table is not written.
- R7: The cycle after `ack_valid` is high with `ack_port`=p, `ret_valid` is 1 and `ret_port` holds the input port of the most recent grant to output port p. In every other cycle `ret_valid` is 0.
- R8: A taken request shows up on the result stream one cycle later. While `res_valid` is high and `res_ready` is low, the result stays unchanged and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_level | input | LVL_W | Tree level of this switch (0 = leaf) |
| cfg_prefix | input | 2*LEVELS | Position prefix of this switch, compared digit by digit |
| up_enable | input | 4 | Bit i enables up link port 4+i |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready |
| req_dest | input | 2*LEVELS | Destination node address |
| req_in_port | input | 3 | Port the packet arrived on |
| res_valid | output | 1 | Result stream valid |
| res_ready | input | 1 | Result stream ready |
| res_port | output | 3 | Granted output port |
| res_up | output | 1 | 1 for an up route |
| res_err | output | 1 | No usable up link for this packet |
| ack_valid | input | 1 | Acknowledge arriving |
| ack_port | input | 3 | Output port the acknowledge arrived on |
| ret_valid | output | 1 | Return port valid |
| ret_port | output | 3 | Port the acknowledge must leave on |

## Verification
The bench sends a run of up-bound packets with equal loads and checks that the grants step across ports 4 to 7 and then wrap back to the lowest port. A design that scans from the wrong end, or lets a later port win a tie, breaks that order at once. It then disables links, including all four. A design that still grants a disabled link, changes a load, or writes the return table on a no-route packet is caught by the later grants and by the acknowledge returns. Acknowledges are sent to lower one link's load and to read the table after it has been overwritten. Level and prefix settings cover both the digit-match and the top-level down decisions. A stall on the result stream checks that the result holds and that no new request is taken.

// File: rtl/ars_pkg.sv
package ars_pkg;
  localparam int NPORT  = 8;
  localparam int NUP    = 4;
  localparam int PORT_W = $clog2(NPORT);
  localparam int UP_W   = $clog2(NUP);
  typedef logic [PORT_W-1:0] port_t;
endpackage

// File: rtl/ars_decide.sv
module ars_decide #(
  parameter int LEVELS = 3,
  parameter int LVL_W  = 2,
  localparam int ADDR_W = 2 * LEVELS
) (
  input  logic [ADDR_W-1:0] dest,
  input  logic [ADDR_W-1:0] prefix,
  input  logic [LVL_W-1:0]  level,
  output logic              go_down,
  output logic [1:0]        down_digit
);
  always_comb begin
    go_down    = 1'b1;
    down_digit = 2'd0;
    for (int i = 0; i < LEVELS; i++) begin
      if (i == int'(level))
        down_digit = dest[2*i +: 2];
      if ((i > int'(level)) && (dest[2*i +: 2] != prefix[2*i +: 2]))
        go_down = 1'b0;
    end
  end
endmodule

// File: rtl/ars_pick.sv
module ars_pick
  import ars_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [NUP-1:0]       en,
  input  logic [NUP*CNT_W-1:0] loads,
  output logic                 found,
  output logic [UP_W-1:0]      sel
);
  logic [CNT_W-1:0] load_a [NUP];

  for (genvar g = 0; g < NUP; g++) begin : g_unpack
    assign load_a[g] = loads[g*CNT_W +: CNT_W];
  end

  always_comb begin
    logic [CNT_W-1:0] best;
    found = 1'b0;
    sel   = '0;
    best  = '0;
    for (int i = 0; i < NUP; i++) begin
      if (en[i] && (!found || (load_a[i] < best))) begin
        found = 1'b1;
        sel   = UP_W'(i);
        best  = load_a[i];
      end
    end
  end
endmodule

// File: rtl/ars_load.sv
module ars_load
  import ars_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inc_valid,
  input  logic [UP_W-1:0]      inc_idx,
  input  logic                 dec_valid,
  input  logic [UP_W-1:0]      dec_idx,
  output logic [NUP*CNT_W-1:0] loads
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar g = 0; g < NUP; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt;
    logic             inc_here;
    logic             dec_here;
    assign inc_here = inc_valid && (inc_idx == UP_W'(g));
    assign dec_here = dec_valid && (dec_idx == UP_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0;
      end else begin
        case ({inc_here, dec_here})
          2'b10:   if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          2'b01:   if (cnt != '0)      cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
    end
    assign loads[g*CNT_W +: CNT_W] = cnt;
  end
endmodule

// File: rtl/ars_retpath.sv
module ars_retpath
  import ars_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  port_t wr_addr,
  input  port_t wr_data,
  input  logic  rd_en,
  input  port_t rd_addr,
  output logic  rd_valid,
  output port_t rd_data
);
  port_t table_q [NPORT];

  for (genvar g = 0; g < NPORT; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        table_q[g] <= '0;
      else if (wr_en && (wr_addr == PORT_W'(g)))
        table_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en)
        rd_data <= table_q[rd_addr];
    end
  end
endmodule

// File: rtl/adaptive_route_sel.sv
module adaptive_route_sel
  import ars_pkg::*;
#(
  parameter int LEVELS = 3,
  parameter int CNT_W  = 4,
  localparam int ADDR_W = 2 * LEVELS,
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  cfg_level,
  input  logic [ADDR_W-1:0] cfg_prefix,
  input  logic [NUP-1:0]    up_enable,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_dest,
  input  logic [PORT_W-1:0] req_in_port,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [PORT_W-1:0] res_port,
  output logic              res_up,
  output logic              res_err,
  input  logic              ack_valid,
  input  logic [PORT_W-1:0] ack_port,
  output logic              ret_valid,
  output logic [PORT_W-1:0] ret_port
);
  logic                 accept;
  logic                 go_down;
  logic [1:0]           down_digit;
  logic                 up_found;
  logic [UP_W-1:0]      up_sel;
  logic [NUP*CNT_W-1:0] loads;
  logic                 no_route;
  logic                 up_grant;
  port_t                grant_port;

  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;

  ars_decide #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_decide (
    .dest       (req_dest),
    .prefix     (cfg_prefix),
    .level      (cfg_level),
    .go_down    (go_down),
    .down_digit (down_digit)
  );

  ars_pick #(.CNT_W(CNT_W)) u_pick (
    .en    (up_enable),
    .loads (loads),
    .found (up_found),
    .sel   (up_sel)
  );

  assign no_route   = !go_down && !up_found;
  assign up_grant   = accept && !go_down && up_found;
  assign grant_port = go_down ? {1'b0, down_digit} : {1'b1, up_sel};

  ars_load #(.CNT_W(CNT_W)) u_load (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_valid (up_grant),
    .inc_idx   (up_sel),
    .dec_valid (ack_valid && ack_port[PORT_W-1]),
    .dec_idx   (ack_port[UP_W-1:0]),
    .loads     (loads)
  );

  ars_retpath u_ret (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (accept && !no_route),
    .wr_addr  (grant_port),
    .wr_data  (req_in_port),
    .rd_en    (ack_valid),
    .rd_addr  (ack_port),
    .rd_valid (ret_valid),
    .rd_data  (ret_port)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_port  <= '0;
      res_up    <= 1'b0;
      res_err   <= 1'b0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_port  <= no_route ? '0 : grant_port;
      res_up    <= !go_down;
      res_err   <= no_route;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ars_chk.sv
module ars_chk
  import ars_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NUP-1:0]    up_enable,
  input logic              req_valid,
  input logic              req_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic [PORT_W-1:0] res_port,
  input logic              res_up,
  input logic              res_err,
  input logic              ack_valid,
  input logic              ret_valid
);
  logic [NUP-1:0] en_q;
  always_ff @(posedge clk) begin
    if (!rst_n)
      en_q <= '0;
    else if (req_valid && req_ready)
      en_q <= up_enable;
  end

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_port) && $stable(res_up) && $stable(res_err));
  // R8
  res_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> res_valid);
  // R4
  up_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_up && !res_err |-> res_port[PORT_W-1]);
  // R2
  down_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_up |-> !res_port[PORT_W-1] && !res_err);
  // R6
  no_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_err |-> res_up && (res_port == '0));
  // R6
  enabled_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_up && !res_err |-> en_q[res_port[UP_W-1:0]]);
  // R7
  ret_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> ret_valid);
  // R7
  ret_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |=> !ret_valid);
endmodule

bind adaptive_route_sel ars_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .up_enable (up_enable),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_port  (res_port),
  .res_up    (res_up),
  .res_err   (res_err),
  .ack_valid (ack_valid),
  .ret_valid (ret_valid)
);

// File: tb/sim_adaptive_route_sel.sv
`timescale 1ns/1ps
module sim_adaptive_route_sel;
  localparam int LEVELS = 3;
  localparam int ADDR_W = 2 * LEVELS;
  localparam int LVL_W  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LVL_W-1:0]  cfg_level = '0;
  logic [ADDR_W-1:0] cfg_prefix = 6'b10_01_00;
  logic [3:0]        up_enable = 4'b1111;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_dest = '0;
  logic [2:0]        req_in_port = '0;
  logic              res_valid;
  logic              res_ready = 1'b1;
  logic [2:0]        res_port;
  logic              res_up;
  logic              res_err;
  logic              ack_valid = 1'b0;
  logic [2:0]        ack_port = '0;
  logic              ret_valid;
  logic [2:0]        ret_port;

  always #5 clk = ~clk;

  adaptive_route_sel #(.LEVELS(LEVELS)) u0 (.*);

  typedef struct { int port; bit up; bit err; string tag; } exp_t;
  exp_t sb[$];
  int load_m [4];
  int rt_m [8];
  int checks = 0;
  int errors = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic exp_t predict(logic [ADDR_W-1:0] d, string tag);
    exp_t e;
    bit down = 1'b1;
    int best = -1;
    for (int k = 0; k < LEVELS; k++)
      if (k > int'(cfg_level) && d[2*k +: 2] != cfg_prefix[2*k +: 2]) down = 1'b0;
    e.tag = tag;
    if (down) begin
      e.up = 0; e.err = 0; e.port = int'(d[2*int'(cfg_level) +: 2]);
    end else begin
      e.up = 1;
      for (int i = 0; i < 4; i++)
        if (up_enable[i] && (best < 0 || load_m[i] < load_m[best])) best = i;
      e.err = (best < 0);
      e.port = (best < 0) ? 0 : 4 + best;
    end
    return e;
  endfunction

  task automatic send(logic [ADDR_W-1:0] d, int inp, string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_dest = d; req_in_port = 3'(inp);
    forever begin
      #4;
      if (req_ready) break;
      @(negedge clk);
    end
    e = predict(d, tag);
    sb.push_back(e);
    if (!e.err) begin
      rt_m[e.port] = inp;
      if (e.up) load_m[e.port-4]++;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ack(int p, string tag);
    int exp_in;
    @(negedge clk);
    ack_valid = 1'b1; ack_port = 3'(p);
    exp_in = rt_m[p];
    if (p >= 4 && load_m[p-4] > 0) load_m[p-4]--;
    @(negedge clk);
    ack_valid = 1'b0;
    #1;
    chk({tag, " ret_valid"}, int'(ret_valid), 1);
    chk({tag, " ret_port"}, int'(ret_port), exp_in);
  endtask

  task automatic drain();
    int n = 0;
    while (sb.size() != 0 && n < 50) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #4;
      if (res_valid && res_ready) begin
        if (sb.size() == 0) begin
          chk("R8 unexpected result", 1, 0);
        end else begin
          e = sb.pop_front();
          chk({e.tag, " port"}, int'(res_port), e.port);
          chk({e.tag, " up"}, int'(res_up), int'(e.up));
          chk({e.tag, " err"}, int'(res_err), int'(e.err));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int held;
    for (int i = 0; i < 4; i++) load_m[i] = 0;
    for (int i = 0; i < 8; i++) rt_m[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 res_valid", int'(res_valid), 0);
    chk("R1 ret_valid", int'(ret_valid), 0);
    chk("R1 req_ready", int'(req_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 digits above level 0 match prefix: down on digit 0
    send(6'b10_01_11, 5, "R2 down digit3");
    send(6'b10_01_00, 7, "R2 down digit0");
    // R4 up with equal loads: lowest port first, then spread
    send(6'b00_01_10, 0, "R4 up tie to 4");
    send(6'b10_00_01, 1, "R4 up next 5");
    send(6'b11_11_11, 2, "R4 up next 6");
    send(6'b01_01_01, 3, "R4 up next 7");
    send(6'b00_00_00, 6, "R4 up wrap 4");
    drain();
    // R5 R7 ack on port 6 lowers its load and returns input 2
    ack(6, "R7 ack port6");
    send(6'b00_11_00, 1, "R5 least loaded 6");
    ack(3, "R7 ack down port3");
    // R5 ack on a down port changes no load: next pick is by loads 2,1,1,1
    send(6'b00_11_01, 4, "R5 after down ack");
    // R6 disabled links skipped
    up_enable = 4'b1100;
    send(6'b01_00_00, 0, "R6 only 6/7 a");
    send(6'b01_00_00, 1, "R6 only 6/7 b");
    send(6'b01_00_00, 2, "R6 only 6/7 c");
    // R6 none enabled: error, no table write, no load change
    up_enable = 4'b0000;
    send(6'b01_00_00, 3, "R6 no route");
    drain();
    ack(4, "R6 table kept port4");
    up_enable = 4'b1111;
    send(6'b11_00_00, 5, "R6 loads unchanged");
    // R5 load stays at zero when acked at zero
    ack(5, "R5 ack5 a");
    ack(5, "R5 ack5 b");
    ack(5, "R5 ack5 c");
    send(6'b11_00_00, 6, "R5 zero floor");
    // R3 top level: always down on digit 2
    cfg_level = 2'd2;
    send(6'b10_00_00, 4, "R3 top down 2");
    send(6'b01_11_11, 5, "R3 top down 1");
    // R2 level 1: digit 2 compared, digit 1 gives port
    cfg_level = 2'd1;
    send(6'b10_11_00, 6, "R2 level1 down 3");
    send(6'b11_11_00, 7, "R4 level1 up");
    drain();
    // R8 stall: result held, no new request taken
    cfg_level = 2'd0;
    res_ready = 1'b0;
    send(6'b10_01_10, 0, "R8 held result");
    #1;
    chk("R8 res_valid in stall", int'(res_valid), 1);
    chk("R8 req_ready in stall", int'(req_ready), 0);
    held = int'(res_port);
    repeat (2) @(negedge clk);
    #1;
    chk("R8 port stable", int'(res_port), held);
    chk("R8 req_ready still low", int'(req_ready), 0);
    res_ready = 1'b1;
    drain();
    chk("R8 queue drained", sb.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule